// File: doc/BRIEF.md
# Peripheral Protection Control Slice

This block holds the security and privilege configuration for a group of up to 32 peripheral ports. For every port it keeps three bits. The first is a non-secure enable bit, which marks the port as reachable by non-secure masters. The second is a privilege-required bit that applies while the port is secure. The third is a privilege-required bit that applies while the port is non-secure. A register decoder elsewhere in the chip drives each write into the slice. The write carries a vector selector, a flag that says whether the access came through the secure or the non-secure register window, and a 32-bit data word. The three vectors are read back zero-extended to 32 bits.

Each port has two outputs. The non-secure output follows the port's enable bit. The access-permission output takes the privilege bit that matches the port's current security state. The port count is a parameter. Written data is cut to that many bits, so unimplemented positions always read back as zero. The block contains no bus protocol and no interrupt logic.

Top module: `ppc_slice`

## Requirements
- R1: While reset is asserted, and right after it is released, all three read-back vectors and both per-port output vectors are zero.
- R2: A write with selector 0 (enable vector) from the secure window (`wr_secure`=1) stores `wr_data` masked to its low NUM_PORTS bits. The result is visible on `rd_nsen` one clock after the write.
- R3: A write with selector 1 (secure-privilege vector) from the secure window stores `wr_data` masked to its low NUM_PORTS bits. The result is visible on `rd_spriv` one clock after the write.
- R4: A write with selector 2 (non-secure-privilege vector) from the non-secure window (`wr_secure`=0) stores `wr_data` masked to its low NUM_PORTS bits. The result is visible on `rd_npriv` one clock after the write.
- R5: `nonsec_o[i]` always equals bit i of the stored enable vector.
- R6: `perm_o[i]` equals bit i of the non-secure-privilege vector when enable bit i is 1. Otherwise it equals bit i of the secure-privilege vector.
- R7: A write with selector 0 or 1 from the non-secure window changes no vector and no output.
- R8: A write with selector 2 from the secure window changes no vector and no output.
- R9: Selector value 3 is reserved. A write with it changes nothing.
- R10: A write changes only the selected vector. Both output vectors show the new value in the cycle after the write, whichever vector was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the register decoder |
| wr_sel | input | 2 | Vector selector: 0 enable, 1 secure privilege, 2 non-secure privilege, 3 reserved |
| wr_secure | input | 1 | 1 when the write came through the secure window |
| wr_data | input | 32 | Write data word |
| rd_nsen | output | 32 | Stored non-secure enable vector, zero-extended |
| rd_spriv | output | 32 | Stored secure-privilege vector, zero-extended |
| rd_npriv | output | 32 | Stored non-secure-privilege vector, zero-extended |
| nonsec_o | output | NUM_PORTS | Per-port non-secure indication |
| perm_o | output | NUM_PORTS | Per-port access-permission bit |

## Verification
The hardest case to reach is the interplay of the permission selector with vectors written at different times. Each port's output must switch source on the cycle after its enable bit flips, while the two privilege vectors hold different values. The stimulus first loads the two privilege vectors with complementary patterns. It then rewrites the enable vector several times, so that every port is sampled both secure and non-secure. Writes through the wrong window and with the reserved selector are placed between these steps, each carrying data that would visibly change the outputs if it were accepted.

// File: rtl/ppc_slice_pkg.sv
package ppc_slice_pkg;

  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    VSEL_NSEN  = 2'd0,
    VSEL_SPRIV = 2'd1,
    VSEL_NPRIV = 2'd2,
    VSEL_RSVD  = 2'd3
  } vsel_e;

  // Mask with the low n bits set.
  function automatic logic [REG_W-1:0] port_mask(input int unsigned n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < REG_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Permission source choice for one port.
  function automatic logic perm_pick(input logic is_ns, input logic np_bit, input logic sp_bit);
    return is_ns ? np_bit : sp_bit;
  endfunction

endpackage

// File: rtl/ppc_write_gate.sv
module ppc_write_gate
  import ppc_slice_pkg::*;
(
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic       wr_secure,
  output logic       ld_nsen,
  output logic       ld_spriv,
  output logic       ld_npriv,
  output logic       wr_reject
);

  vsel_e sel;
  assign sel = vsel_e'(wr_sel);

  always_comb begin
    ld_nsen   = 1'b0;
    ld_spriv  = 1'b0;
    ld_npriv  = 1'b0;
    wr_reject = 1'b0;
    if (wr_en) begin
      unique case (sel)
        VSEL_NSEN:  if (wr_secure)  ld_nsen  = 1'b1; else wr_reject = 1'b1;
        VSEL_SPRIV: if (wr_secure)  ld_spriv = 1'b1; else wr_reject = 1'b1;
        VSEL_NPRIV: if (!wr_secure) ld_npriv = 1'b1; else wr_reject = 1'b1;
        default:    wr_reject = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/ppc_vec_reg.sv
module ppc_vec_reg
  import ppc_slice_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [REG_W-1:0] d,
  output logic [REG_W-1:0] q
);

  localparam logic [REG_W-1:0] KEEP = port_mask(NUM_PORTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d & KEEP;
  end

endmodule

// File: rtl/ppc_perm_mux.sv
module ppc_perm_mux
  import ppc_slice_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 16
) (
  input  logic [NUM_PORTS-1:0] nsen,
  input  logic [NUM_PORTS-1:0] spriv,
  input  logic [NUM_PORTS-1:0] npriv,
  output logic [NUM_PORTS-1:0] perm
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign perm[p] = perm_pick(nsen[p], npriv[p], spriv[p]);
  end

endmodule

// File: rtl/ppc_slice.sv
module ppc_slice
  import ppc_slice_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic                 wr_secure,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_nsen,
  output logic [31:0]          rd_spriv,
  output logic [31:0]          rd_npriv,
  output logic [NUM_PORTS-1:0] nonsec_o,
  output logic [NUM_PORTS-1:0] perm_o
);

  logic ld_nsen, ld_spriv, ld_npriv, wr_reject;

  ppc_write_gate u_gate (
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_secure (wr_secure),
    .ld_nsen   (ld_nsen),
    .ld_spriv  (ld_spriv),
    .ld_npriv  (ld_npriv),
    .wr_reject (wr_reject)
  );

  ppc_vec_reg #(.NUM_PORTS(NUM_PORTS)) u_nsen (
    .clk(clk), .rst_n(rst_n), .ld(ld_nsen),  .d(wr_data), .q(rd_nsen));
  ppc_vec_reg #(.NUM_PORTS(NUM_PORTS)) u_spriv (
    .clk(clk), .rst_n(rst_n), .ld(ld_spriv), .d(wr_data), .q(rd_spriv));
  ppc_vec_reg #(.NUM_PORTS(NUM_PORTS)) u_npriv (
    .clk(clk), .rst_n(rst_n), .ld(ld_npriv), .d(wr_data), .q(rd_npriv));

  assign nonsec_o = rd_nsen[NUM_PORTS-1:0];

  ppc_perm_mux #(.NUM_PORTS(NUM_PORTS)) u_perm (
    .nsen  (rd_nsen[NUM_PORTS-1:0]),
    .spriv (rd_spriv[NUM_PORTS-1:0]),
    .npriv (rd_npriv[NUM_PORTS-1:0]),
    .perm  (perm_o)
  );

endmodule

// File: rtl/ppc_slice_chk.sv
module ppc_slice_chk
  import ppc_slice_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [1:0]           wr_sel,
  input logic                 wr_secure,
  input logic [31:0]          wr_data,
  input logic [31:0]          rd_nsen,
  input logic [31:0]          rd_spriv,
  input logic [31:0]          rd_npriv,
  input logic [NUM_PORTS-1:0] nonsec_o,
  input logic [NUM_PORTS-1:0] perm_o,
  input logic                 ld_nsen,
  input logic                 ld_spriv,
  input logic                 ld_npriv,
  input logic                 wr_reject
);

  localparam logic [31:0] M = port_mask(NUM_PORTS);

  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |-> (rd_nsen == '0 && rd_spriv == '0 && rd_npriv == '0 && nonsec_o == '0 && perm_o == '0));

  a_r2_nsen_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && wr_secure) |=> rd_nsen == ($past(wr_data) & M));

  a_r3_spriv_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && wr_secure) |=> rd_spriv == ($past(wr_data) & M));

  a_r4_npriv_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && !wr_secure) |=> rd_npriv == ($past(wr_data) & M));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_nsen | rd_spriv | rd_npriv) & ~M) == '0);

  a_r5_nonsec_follows: assert property (@(posedge clk) disable iff (!rst_n)
    nonsec_o == rd_nsen[NUM_PORTS-1:0]);

  a_r6_perm_select: assert property (@(posedge clk) disable iff (!rst_n)
    perm_o == ((nonsec_o & rd_npriv[NUM_PORTS-1:0]) | (~nonsec_o & rd_spriv[NUM_PORTS-1:0])));

  a_r7_ns_window_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_secure && wr_sel != 2'd2) |=> ($stable(rd_nsen) && $stable(rd_spriv)));

  a_r8_s_window_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_secure && wr_sel == 2'd2) |=> $stable(rd_npriv));

  a_r9_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> ($stable(rd_nsen) && $stable(rd_spriv) && $stable(rd_npriv)
                   && $stable(nonsec_o) && $stable(perm_o)));

  a_r10_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_nsen, ld_spriv, ld_npriv, wr_reject}));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(nonsec_o) && $stable(perm_o)));

endmodule

bind ppc_slice ppc_slice_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (.*);

// File: tb/test_ppc_slice.sv
`timescale 1ns/1ps
module test_ppc_slice;

  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic          wr_secure = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_nsen, rd_spriv, rd_npriv;
  logic [N-1:0]  nonsec_o, perm_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ppc_slice #(.NUM_PORTS(N)) i_ppc_slice (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_secure(wr_secure), .wr_data(wr_data), .rd_nsen(rd_nsen),
    .rd_spriv(rd_spriv), .rd_npriv(rd_npriv), .nonsec_o(nonsec_o), .perm_o(perm_o)
  );

  // Behavioural reference: three integers, one per vector.
  longint unsigned ref_en, ref_sp, ref_np;
  longint unsigned lim;
  initial lim = (longint'(1) << N);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_en = 0; ref_sp = 0; ref_np = 0;
    end else if (wr_en) begin
      if (wr_sel == 2'd0 && wr_secure == 1'b1) ref_en = longint'(wr_data) % lim;
      if (wr_sel == 2'd1 && wr_secure == 1'b1) ref_sp = longint'(wr_data) % lim;
      if (wr_sel == 2'd2 && wr_secure == 1'b0) ref_np = longint'(wr_data) % lim;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_perm();
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      if ((ref_en >> i) & 1) r[i] = (ref_np >> i) & 1;
      else                   r[i] = (ref_sp >> i) & 1;
    end
    return r;
  endfunction

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 rd_nsen",  rd_nsen,  32'(ref_en));
      check("R3 rd_spriv", rd_spriv, 32'(ref_sp));
      check("R4 rd_npriv", rd_npriv, 32'(ref_np));
      check("R5 nonsec_o", 32'(nonsec_o), 32'(ref_en));
      check("R6 perm_o",   32'(perm_o), ref_perm());
    end
  end

  task automatic wr(input logic [1:0] sel, input logic sec, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_secure = sec; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'hDEAD_BEEF;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    idle(3);
    // R1: values during reset
    check("R1 nsen in reset", rd_nsen, 32'h0);
    check("R1 perm in reset", 32'(perm_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release nsen",  rd_nsen, 32'h0);
    check("R1 after release spriv", rd_spriv, 32'h0);
    check("R1 after release npriv", rd_npriv, 32'h0);
    check("R1 after release outs",  32'({nonsec_o, perm_o}), 32'h0);

    // R3/R4: complementary privilege patterns, upper bits masked
    wr(2'd1, 1'b1, 32'hFFFF_00FF);
    check("R3 spriv masked", rd_spriv, 32'h0000_00FF);
    check("R6 all secure uses spriv", 32'(perm_o), 32'h0000_00FF);
    wr(2'd2, 1'b0, 32'hABCD_FF00);
    check("R4 npriv masked", rd_npriv, 32'h0000_FF00);
    check("R10 perm unchanged while secure", 32'(perm_o), 32'h0000_00FF);

    // R2/R10: enable flips; outputs move exactly one cycle after the write
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_secure = 1'b1; wr_data = 32'h1234_F0F0;
    check("R10 no change before edge", 32'(nonsec_o), 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R2 nsen masked", rd_nsen, 32'h0000_F0F0);
    check("R5 nonsec after write", 32'(nonsec_o), 32'h0000_F0F0);
    check("R6 mixed ports", 32'(perm_o), 32'h0000_F000 | 32'h0000_000F);

    wr(2'd0, 1'b1, 32'hFFFF_FFFF);
    check("R6 all non-secure uses npriv", 32'(perm_o), 32'h0000_FF00);

    // R7: secure-only vectors written from non-secure window
    wr(2'd0, 1'b0, 32'h0000_0000);
    check("R7 nsen unchanged", rd_nsen, 32'h0000_FFFF);
    wr(2'd1, 1'b0, 32'h0000_FFFF);
    check("R7 spriv unchanged", rd_spriv, 32'h0000_00FF);
    check("R7 perm unchanged", 32'(perm_o), 32'h0000_FF00);

    // R8: non-secure-privilege vector written from secure window
    wr(2'd2, 1'b1, 32'h0000_0000);
    check("R8 npriv unchanged", rd_npriv, 32'h0000_FF00);
    check("R8 perm unchanged", 32'(perm_o), 32'h0000_FF00);

    // R9: reserved selector from either window
    wr(2'd3, 1'b1, 32'h0000_0000);
    wr(2'd3, 1'b0, 32'h0000_0000);
    check("R9 nsen unchanged", rd_nsen, 32'h0000_FFFF);
    check("R9 perm unchanged", 32'(perm_o), 32'h0000_FF00);

    // R10: privilege write alone updates permission outputs
    wr(2'd2, 1'b0, 32'h0000_5555);
    check("R10 perm follows npriv write", 32'(perm_o), 32'h0000_5555);
    wr(2'd0, 1'b1, 32'h0000_00FF);
    wr(2'd1, 1'b1, 32'h0000_AAAA);
    check("R10 perm follows spriv write", 32'(perm_o), 32'h0000_AA55);

    // Sweep of enable patterns against reference
    for (int k = 0; k < 40; k++) begin
      wr(2'(k % 4), 1'(k % 3 == 0), 32'h9E37_79B9 * (k + 1));
    end

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset nsen", rd_nsen, 32'h0);
    check("R1 re-reset npriv", rd_npriv, 32'h0);
    check("R1 re-reset outs", 32'({nonsec_o, perm_o}), 32'h0);
    rst_n = 1'b1;
    idle(2);
    summary();
  end

endmodule